// File: doc/BRIEF.md
# Calendar Timekeeper With Centiseconds

A synchronous calendar counter for a real-time clock. A one-cycle enable, `tick`, arrives one hundred times a second and advances the hundredths field. Carries run up through seconds, minutes and hours, then into the day of week, the day of the month, the month and the year. Every field is kept in binary-coded decimal. The day-of-month counter ends each month on the correct day: the short months have 30 days, and February has 28 or 29 days depending on the year field.

The hour field runs in one of two formats. In 24-hour form it counts 00 to 23. In 12-hour form it counts 12, 01 to 11, and keeps a separate afternoon flag. The format is a bit inside the stored word, so software changes it at runtime by loading a new word.

An external access controller reads the whole time as one 64-bit word. It sets the time by pulsing `load` with a replacement word for a single cycle. A load and a tick in the same cycle resolve in favour of the load.

Top module: `tk_calendar`

## Requirements
- R1: After reset, with the default parameters, `time_word` reads 64'h0001_0101_0000_0000. That is 00:00:00.00 in 24-hour form, day of week 1, date 01, month 01 and year 00.
- R2: In a cycle with neither `tick` nor `load` high, `time_word` does not change on the next clock edge.
- R3: Each `tick` adds one to the hundredths field, which counts BCD 00 to 99. Seconds and minutes count BCD 00 to 59. Each field wraps to 00 and carries into the next field only when it is at its maximum and a carry reaches it.
- R4: When byte 3 bit 7 is 0 (24-hour form), bits 5:0 of that byte hold the hour as BCD 00 to 23. An increment from 23 gives 00 and advances the day.
- R5: When byte 3 bit 7 is 1 (12-hour form), bits 4:0 hold the hour as BCD 01 to 12 and bit 5 is the afternoon flag (1 = PM). An increment from 11 gives 12 and toggles the flag. An increment from 12 gives 01 and leaves the flag unchanged. The day advances only on the step from 11 PM to 12 AM. Bit 6 always reads 0.
- R6: The day of week is held in byte 4 bits 2:0 with values 1 to 7, and bits 7:3 read 0. Each day advance steps it by one, and 7 steps to 1.
- R7: The date is held in byte 5 as BCD. Months 04, 06, 09 and 11 end after 30, and all months other than 02 end after 31. At a month end the date becomes 01 and the month (byte 6, BCD 01 to 12) advances. Month 12 steps to 01 and advances the year (byte 7, BCD 00 to 99). Year 99 steps to 00.
- R8: February ends after 29 when the year value is divisible by 4, year 00 included, and after 28 in any other year.
- R9: A `load` pulse replaces every field in one clock cycle, so the next cycle reads `load_word` back. Bits the layout defines as zero are the exception. A `tick` in the same cycle as a load is ignored.
- R10: The word is packed little-end first. Byte 0 is hundredths, byte 1 seconds, byte 2 minutes, byte 3 hours with the format and flag bits, byte 4 day of week, byte 5 date, byte 6 month and byte 7 year.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle enable at 100 Hz that advances the hundredths |
| load | input | 1 | One-cycle strobe that replaces all fields with `load_word` |
| load_word | input | 64 | Replacement time word, in the same layout as `time_word` |
| time_word | output | 64 | Current time and calendar, packed as described in R10 |

## Verification
A parallel load and a 100 Hz tick can land in the same clock cycle. The bench drives both high together, first on an ordinary time value and then on a value one tick short of a carry. It judges the result by expecting the loaded word back unchanged, with no hundredth added and no carry propagated. The month-end, leap-year and 11 PM rollovers are each provoked the same way: the bench loads a value a few hundredths before the boundary, then ticks across it. An independent binary reference model supplies the expected words.

// File: rtl/tk_pkg.sv
package tk_pkg;
   localparam int BYTE_W   = 8;
   localparam int N_FIELDS = 8;
   localparam int WORD_W   = BYTE_W * N_FIELDS;

   typedef logic [BYTE_W-1:0] bcd8_t;

   // add one to a two-digit BCD value (no wrap at 99 here)
   function automatic bcd8_t bcd_inc(input bcd8_t v);
      bcd8_t r;
      if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
      else                r = {v[7:4], v[3:0] + 4'd1};
      return r;
   endfunction

   // BCD year divisible by four: even tens with units 0/4/8, odd tens with 2/6
   function automatic logic bcd_year_leap(input bcd8_t y);
      logic r;
      if (!y[4]) r = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
      else       r = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
      return r;
   endfunction

   function automatic bcd8_t bcd_month_end(input bcd8_t mon, input logic leap);
      bcd8_t r;
      case (mon)
         8'h02:                      r = leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
         default:                    r = 8'h31;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/tk_wrap_cnt.sv
module tk_wrap_cnt #(
   parameter int         WIDTH = 8,
   parameter logic [7:0] LO    = 8'h00,
   parameter logic [7:0] HI    = 8'h59,
   parameter logic [7:0] RST   = LO
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   input  logic             inc,
   output logic [WIDTH-1:0] value,
   output logic             carry
);
   import tk_pkg::*;

   localparam logic [WIDTH-1:0] LO_W  = LO[WIDTH-1:0];
   localparam logic [WIDTH-1:0] HI_W  = HI[WIDTH-1:0];
   localparam logic [WIDTH-1:0] RST_W = RST[WIDTH-1:0];

   generate
      if (WIDTH < 1 || WIDTH > BYTE_W) begin : g_bad_width
         $error("tk_wrap_cnt: WIDTH must be 1..8");
      end
      if (HI <= LO) begin : g_bad_range
         $error("tk_wrap_cnt: HI must exceed LO");
      end
   endgenerate

   logic [WIDTH-1:0] q;
   bcd8_t            wide_q, wide_n;
   logic             unused_wide;

   always_comb begin
      wide_q            = '0;
      wide_q[WIDTH-1:0] = q;
      wide_n            = bcd_inc(wide_q);
   end
   assign unused_wide = ^wide_n;

   assign carry = inc & (q >= HI_W);
   assign value = q;

   always_ff @(posedge clk) begin
      if (!rst_n)    q <= RST_W;
      else if (load) q <= load_val;
      else if (inc)  q <= (q >= HI_W) ? LO_W : wide_n[WIDTH-1:0];
   end
endmodule

// File: rtl/tk_hour_cnt.sv
module tk_hour_cnt #(
   parameter bit RST_12H = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  tk_pkg::bcd8_t  load_val,
   input  logic           inc,
   output tk_pkg::bcd8_t  hour_byte,
   output logic           day_carry
);
   import tk_pkg::*;

   localparam logic [5:0] RST_HV = RST_12H ? 6'h12 : 6'h00;

   logic       mode12, pm;
   logic [5:0] hv, hv_inc, hv_nxt;
   logic       pm_nxt;
   bcd8_t      w;
   logic       unused_hour;

   assign w           = bcd_inc({2'b00, hv});
   assign hv_inc      = w[5:0];
   assign unused_hour = ^{w[7:6], load_val[6]};

   generate
      if (RST_12H) begin : g_rst12
         initial begin end
      end
   endgenerate

   always_comb begin
      hv_nxt    = hv_inc;
      pm_nxt    = pm;
      day_carry = 1'b0;
      if (mode12) begin
         if (hv >= 6'h12) hv_nxt = 6'h01;
         if (hv == 6'h11) begin
            pm_nxt    = ~pm;
            day_carry = inc & pm;
         end
      end else if (hv >= 6'h23) begin
         hv_nxt    = 6'h00;
         day_carry = inc;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode12 <= RST_12H;
         pm     <= 1'b0;
         hv     <= RST_HV;
      end else if (load) begin
         mode12 <= load_val[7];
         pm     <= load_val[7] & load_val[5];
         hv     <= load_val[7] ? {1'b0, load_val[4:0]} : load_val[5:0];
      end else if (inc) begin
         pm <= pm_nxt;
         hv <= hv_nxt;
      end
   end

   assign hour_byte = {mode12, 1'b0, mode12 ? {pm, hv[4:0]} : hv};
endmodule

// File: rtl/tk_date_cnt.sv
module tk_date_cnt (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  tk_pkg::bcd8_t  load_val,
   input  logic           inc,
   input  tk_pkg::bcd8_t  last_day,
   output tk_pkg::bcd8_t  date,
   output logic           carry
);
   import tk_pkg::*;

   bcd8_t q;

   assign carry = inc & (q >= last_day);
   assign date  = q;

   always_ff @(posedge clk) begin
      if (!rst_n)    q <= 8'h01;
      else if (load) q <= load_val;
      else if (inc)  q <= (q >= last_day) ? 8'h01 : bcd_inc(q);
   end
endmodule

// File: rtl/tk_calendar.sv
module tk_calendar #(
   parameter bit RST_12H = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick,
   input  logic        load,
   input  logic [63:0] load_word,
   output logic [63:0] time_word
);
   import tk_pkg::*;

   localparam int N_SUB = 3;   // hundredths, seconds, minutes

   generate
      if (WORD_W != 64) begin : g_bad_word
         $error("tk_calendar: word must be 64 bits");
      end
   endgenerate

   logic [N_SUB:0] chain;
   bcd8_t          sub_val [N_SUB];
   bcd8_t          hour_b, date_b, mon_b, year_b;
   logic [2:0]     dow_v;
   logic           day_c, mon_c, year_c, year_wrap;
   logic           unused_bits;

   assign chain[0] = tick;

   genvar i;
   generate
      for (i = 0; i < N_SUB; i++) begin : g_sub
         localparam logic [7:0] TOP = (i == 0) ? 8'h99 : 8'h59;
         tk_wrap_cnt #(.WIDTH(BYTE_W), .LO(8'h00), .HI(TOP), .RST(8'h00)) u_cnt (
            .clk(clk), .rst_n(rst_n), .load(load),
            .load_val(load_word[i*BYTE_W +: BYTE_W]),
            .inc(chain[i]), .value(sub_val[i]), .carry(chain[i+1]));
      end
   endgenerate

   tk_hour_cnt #(.RST_12H(RST_12H)) u_hour (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_word[31:24]),
      .inc(chain[N_SUB]), .hour_byte(hour_b), .day_carry(day_c));

   logic dow_wrap;
   tk_wrap_cnt #(.WIDTH(3), .LO(8'd1), .HI(8'd7), .RST(8'd1)) u_dow (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_word[34:32]),
      .inc(day_c), .value(dow_v), .carry(dow_wrap));

   tk_date_cnt u_date (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_word[47:40]),
      .inc(day_c), .last_day(bcd_month_end(mon_b, bcd_year_leap(year_b))),
      .date(date_b), .carry(mon_c));

   tk_wrap_cnt #(.WIDTH(BYTE_W), .LO(8'h01), .HI(8'h12), .RST(8'h01)) u_mon (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_word[55:48]),
      .inc(mon_c), .value(mon_b), .carry(year_c));

   tk_wrap_cnt #(.WIDTH(BYTE_W), .LO(8'h00), .HI(8'h99), .RST(8'h00)) u_year (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_word[63:56]),
      .inc(year_c), .value(year_b), .carry(year_wrap));

   assign unused_bits = ^{load_word[39:35], dow_wrap, year_wrap};

   assign time_word = {year_b, mon_b, date_b, 5'b00000, dow_v, hour_b,
                       sub_val[2], sub_val[1], sub_val[0]};
endmodule

// File: rtl/tk_calendar_chk.sv
module tk_calendar_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        tick,
   input logic        load,
   input logic [63:0] load_word,
   input logic [63:0] time_word
);
   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(time_word));

   a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (time_word[23:0] == $past(load_word[23:0]) &&
                time_word[63:40] == $past(load_word[63:40])));

   a_r3_centi_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && time_word[7:0] == 8'h99) |=> (time_word[7:0] == 8'h00));

   a_r4_midnight: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && time_word[31:0] == 32'h2359_5999) |=> (time_word[31:0] == 32'h0));

   a_r5_noon_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && time_word[31:0] == 32'h9159_5999) |=> (time_word[31:24] == 8'hB2));
endmodule

bind tk_calendar tk_calendar_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
   .load_word(load_word), .time_word(time_word));

// File: tb/sim_tk_calendar.sv
`timescale 1ns/1ps
module sim_tk_calendar;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        load = 1'b0;
   logic [63:0] load_word = '0;
   logic [63:0] time_word;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [63:0] exp_q[$];
   string       tag_q[$];

   // reference model in plain binary
   int m_cs = 0, m_s = 0, m_m = 0, m_h = 0, m_dow = 1, m_date = 1, m_mon = 1, m_yr = 0;
   bit m_12 = 1'b0;

   always #2.5 clk = ~clk;

   tk_calendar u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
                   .load_word(load_word), .time_word(time_word));

   function automatic logic [7:0] bcd(input int v);
      return 8'((v / 10) * 16 + (v % 10));
   endfunction

   function automatic int mdays(input int mon, input int yr);
      if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
      return 31;
   endfunction

   function automatic logic [63:0] pack();
      logic [7:0] hb;
      int h12;
      if (m_12) begin
         h12 = (m_h % 12 == 0) ? 12 : m_h % 12;
         hb  = 8'h80 | ((m_h >= 12) ? 8'h20 : 8'h00) | bcd(h12);
      end else hb = bcd(m_h);
      // R10: byte 0 hundredths ... byte 7 year
      return {bcd(m_yr), bcd(m_mon), bcd(m_date), 8'(m_dow), hb,
              bcd(m_m), bcd(m_s), bcd(m_cs)};
   endfunction

   task automatic advance();
      m_cs++;
      if (m_cs == 100) begin m_cs = 0; m_s++; end
      if (m_s == 60) begin m_s = 0; m_m++; end
      if (m_m == 60) begin m_m = 0; m_h++; end
      if (m_h == 24) begin
         m_h = 0;
         m_dow = (m_dow == 7) ? 1 : m_dow + 1;
         m_date++;
         if (m_date > mdays(m_mon, m_yr)) begin
            m_date = 1; m_mon++;
            if (m_mon > 12) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
         end
      end
   endtask

   // driver: drives one cycle and queues the expected word
   task automatic cyc(input bit tk, input bit ld, input string tag);
      @(negedge clk);
      tick = tk; load = ld;
      load_word = pack();
      if (!ld && tk) advance();
      exp_q.push_back(pack());
      tag_q.push_back(tag);
   endtask

   task automatic set_t(input int yr, input int mon, input int dt, input int dw,
                        input int h24, input int mi, input int se, input int cs,
                        input bit twelve, input string tag);
      m_yr = yr; m_mon = mon; m_date = dt; m_dow = dw; m_h = h24;
      m_m = mi; m_s = se; m_cs = cs; m_12 = twelve;
      cyc(1'b0, 1'b1, tag);
   endtask

   task automatic ticks(input int n, input string tag);
      for (int k = 0; k < n; k++) cyc(1'b1, 1'b0, tag);
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk); #1;
         if (exp_q.size() > 0) begin
            logic [63:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (time_word !== e) begin
               errors++;
               $display("FAIL %s actual %h expected %h", t, time_word, e);
            end
         end
      end
   end

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      cyc(1'b0, 1'b0, "R1");                        // R1 reset word
      if (pack() != 64'h0001_0101_0000_0000) $display("model mismatch");
      ticks(250, "R3");                              // R3 hundredths into seconds
      for (int k = 0; k < 4; k++) cyc(1'b0, 1'b0, "R2");   // R2 idle hold
      set_t(23, 4, 3, 2, 0, 59, 59, 97, 1'b0, "R9");
      ticks(5, "R3");                                // R3 minute to hour carry
      set_t(23, 4, 30, 3, 23, 59, 59, 97, 1'b0, "R9");
      ticks(4, "R4");                                // R4 and R7 30-day month end
      set_t(23, 8, 15, 7, 23, 59, 59, 99, 1'b0, "R9");
      ticks(2, "R6");                                // R6 dow 7 -> 1
      set_t(23, 8, 30, 2, 23, 59, 59, 99, 1'b0, "R9");
      ticks(1, "R7");                                // R7 Aug 30 -> 31
      set_t(23, 8, 31, 3, 23, 59, 59, 99, 1'b0, "R9");
      ticks(1, "R7");
      set_t(99, 12, 31, 5, 23, 59, 59, 98, 1'b0, "R9");
      ticks(3, "R7");                                // R7 year 99 -> 00
      set_t(23, 2, 28, 2, 23, 59, 59, 99, 1'b0, "R9");
      ticks(1, "R8");                                // R8 non-leap
      set_t(24, 2, 28, 3, 23, 59, 59, 99, 1'b0, "R9");
      ticks(1, "R8");                                // R8 leap
      ticks(100 * 60 * 60 * 0 + 1, "R8");
      set_t(24, 2, 29, 4, 23, 59, 59, 99, 1'b0, "R9");
      ticks(1, "R8");
      set_t(0, 2, 28, 1, 23, 59, 59, 99, 1'b0, "R9");
      ticks(1, "R8");                                // R8 year 00 is leap
      set_t(23, 6, 10, 1, 11, 59, 59, 98, 1'b1, "R9");
      ticks(3, "R5");                                // R5 11 AM -> 12 PM
      set_t(23, 6, 10, 1, 12, 59, 59, 99, 1'b1, "R9");
      ticks(2, "R5");                                // R5 12 PM -> 1 PM
      set_t(23, 6, 30, 1, 23, 59, 59, 99, 1'b1, "R9");
      ticks(2, "R5");                                // R5 11 PM -> 12 AM, next day
      set_t(23, 6, 10, 1, 0, 59, 59, 99, 1'b1, "R9");
      ticks(1, "R5");                                // R5 12 AM -> 1 AM
      m_12 = 1'b0; cyc(1'b0, 1'b1, "R10");           // R10 mode switch via load
      m_yr = 47; m_mon = 9; m_date = 21; m_dow = 6; m_h = 13; m_m = 45; m_s = 7; m_cs = 62;
      cyc(1'b1, 1'b1, "R9");                         // R9 load wins over tick
      if (pack() != 64'h4709_2106_1345_0762) begin
         checks++; errors++;
         $display("FAIL R10 actual %h expected %h", pack(), 64'h4709_2106_1345_0762);
      end else checks++;
      m_h = 23; m_m = 59; m_s = 59; m_cs = 99;
      cyc(1'b1, 1'b1, "R9");                         // R9 load at carry edge
      cyc(1'b0, 1'b0, "R2");
      while (exp_q.size() > 0) @(negedge clk);
      @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule